// File: doc/BRIEF.md
# Four-Channel Match Timer

A free-running 32-bit counter advances by one whenever the tick strobe is high and is compared against four independent 32-bit match registers. On every tick the count held before the increment is checked against all four registers; each equality latches a bit in a 4-bit status register. Several bits may latch on the same tick. Software clears status bits by writing ones to them. A 4-bit interrupt enable gates each status bit onto its own interrupt request line.

The block also holds a sticky watchdog-enable bit. Software can set this bit but cannot clear it; only reset clears it. The enable bit and the channel-3 status bit are driven out for a reset controller elsewhere. Register access uses single-cycle write and read strobes with a 3-bit word index, where the byte offset is four times the index. Read data is registered and appears the cycle after the read strobe.

Top module: `match_timer`

## Requirements
- R1: After reset the counter, all match registers, status, interrupt enable and watchdog enable read as zero, and irq_o is zero.
- R2: A cycle with tick_i high and no count write raises the counter by one. Without a tick the counter holds.
- R3: On a tick, status bit n latches when the pre-increment count equals match register n (word index n, 0 to 3). Several bits may latch on one tick.
- R4: A write to the status register (index 5) clears each status bit whose position is 1 in wdata_i[3:0]. Zero bits leave status unchanged.
- R5: If a tick latches a status bit in the same cycle that a status write clears it, the bit ends up set.
- R6: A write to the interrupt enable (index 7) stores wdata_i[3:0]. It reads back with bits 31:4 zero.
- R7: A write to the watchdog enable (index 6) ORs wdata_i[0] into the stored bit, so a write of 0 never clears it. The bit reads back at bit 0 and drives wdog_en_o.
- R8: irq_o[n] is high exactly when interrupt enable bit n and status bit n are both 1.
- R9: The counter (index 4) is writable. A write in the same cycle as a tick loads the written value, not the incremented one. The counter wraps from 0xFFFFFFFF to 0.
- R10: When rd_en_i is high, rdata_o takes the addressed register one cycle later, with unused bits zero. Without a read, rdata_o holds its value.
- R11: wdog_match_o equals status bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timer advance strobe |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Word index (byte offset / 4) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 4 | Per-channel interrupt requests |
| wdog_en_o | output | 1 | Sticky watchdog enable |
| wdog_match_o | output | 1 | Channel-3 status bit |

## Verification
The hardest case to reach is a collision in a single cycle: a tick whose compare latches a status bit while a status write clears that same bit, or a tick that arrives together with a count write. The bench presets the counter so that the compare lands on a known match value, then issues the write with tick_i high in the same cycle. It then reads status and count back to see which action won. Wrap-around is reached by preloading 0xFFFFFFFF, so the bench does not have to count up to it.

// File: rtl/match_timer_pkg.sv
package match_timer_pkg;
  typedef enum logic [2:0] {
    IDX_MATCH0 = 3'd0,
    IDX_MATCH1 = 3'd1,
    IDX_MATCH2 = 3'd2,
    IDX_MATCH3 = 3'd3,
    IDX_COUNT  = 3'd4,
    IDX_STATUS = 3'd5,
    IDX_WDOG   = 3'd6,
    IDX_IEN    = 3'd7
  } reg_idx_e;
endpackage

// File: rtl/mt_counter.sv
module mt_counter #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] count_o
);
  logic [W-1:0] count_q;

  // software load wins over tick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     count_q <= '0;
    else if (load_i) count_q <= load_val_i;
    else if (tick_i) count_q <= count_q + W'(1);
  end

  assign count_o = count_q;
endmodule

// File: rtl/mt_match_bank.sv
module mt_match_bank #(
  parameter int W = 32,
  parameter int N = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N-1:0]        we_i,
  input  logic [W-1:0]        wdata_i,
  input  logic                tick_i,
  input  logic [W-1:0]        count_i,
  output logic [N-1:0][W-1:0] match_o,
  output logic [N-1:0]        hit_o
);
  for (genvar c = 0; c < N; c++) begin : g_ch
    logic [W-1:0] match_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      match_q <= '0;
      else if (we_i[c]) match_q <= wdata_i;
    end

    assign match_o[c] = match_q;
    assign hit_o[c]   = tick_i && (count_i == match_q);
  end
endmodule

// File: rtl/mt_status.sv
module mt_status #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] status_o
);
  logic [N-1:0] status_q;

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_i) | set_i;
  end

  assign status_o = status_q;
endmodule

// File: rtl/match_timer.sv
module match_timer
  import match_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CH_N   = 4,
  parameter int ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [CH_N-1:0]   irq_o,
  output logic              wdog_en_o,
  output logic              wdog_match_o
);
  localparam int PAD_W = DATA_W - CH_N;

  logic [DATA_W-1:0]            count;
  logic [CH_N-1:0][DATA_W-1:0]  match;
  logic [CH_N-1:0]              hit, status, clr, match_we;
  logic [CH_N-1:0]              ien_q;
  logic                         wdog_q;
  logic                         cnt_we, sts_we, ien_we, wdog_we;
  logic [DATA_W-1:0]            rd_mux, rdata_q;

  assign cnt_we  = wr_en_i && (addr_i == ADDR_W'(IDX_COUNT));
  assign sts_we  = wr_en_i && (addr_i == ADDR_W'(IDX_STATUS));
  assign ien_we  = wr_en_i && (addr_i == ADDR_W'(IDX_IEN));
  assign wdog_we = wr_en_i && (addr_i == ADDR_W'(IDX_WDOG));

  for (genvar c = 0; c < CH_N; c++) begin : g_we
    assign match_we[c] = wr_en_i && (addr_i == ADDR_W'(c));
  end

  assign clr = sts_we ? wdata_i[CH_N-1:0] : '0;

  mt_counter #(.W(DATA_W)) u_counter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .load_i     (cnt_we),
    .load_val_i (wdata_i),
    .count_o    (count)
  );

  mt_match_bank #(.W(DATA_W), .N(CH_N)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (match_we),
    .wdata_i (wdata_i),
    .tick_i  (tick_i),
    .count_i (count),
    .match_o (match),
    .hit_o   (hit)
  );

  mt_status #(.N(CH_N)) u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (hit),
    .clr_i    (clr),
    .status_o (status)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q  <= '0;
      wdog_q <= 1'b0;
    end else begin
      if (ien_we)  ien_q  <= wdata_i[CH_N-1:0];
      if (wdog_we) wdog_q <= wdog_q | wdata_i[0];
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int c = 0; c < CH_N; c++)
      if (addr_i == ADDR_W'(c)) rd_mux = match[c];
    unique case (addr_i)
      ADDR_W'(IDX_COUNT):  rd_mux = count;
      ADDR_W'(IDX_STATUS): rd_mux = {{PAD_W{1'b0}}, status};
      ADDR_W'(IDX_WDOG):   rd_mux = {{(DATA_W-1){1'b0}}, wdog_q};
      ADDR_W'(IDX_IEN):    rd_mux = {{PAD_W{1'b0}}, ien_q};
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end

  assign rdata_o      = rdata_q;
  assign irq_o        = ien_q & status;
  assign wdog_en_o    = wdog_q;
  assign wdog_match_o = status[CH_N-1];
endmodule

// File: rtl/mt_checker.sv
module mt_checker #(
  parameter int DATA_W = 32,
  parameter int CH_N   = 4,
  parameter int ADDR_W = 3
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       tick_i,
  input logic                       wr_en_i,
  input logic                       rd_en_i,
  input logic [ADDR_W-1:0]          addr_i,
  input logic [DATA_W-1:0]          wdata_i,
  input logic [DATA_W-1:0]          rdata_o,
  input logic                       wdog_en_o,
  input logic                       wdog_match_o,
  input logic [DATA_W-1:0]          count,
  input logic [CH_N-1:0][DATA_W-1:0] match,
  input logic [CH_N-1:0]            status,
  input logic [CH_N-1:0]            ien_q
);
  // R2
  count_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !(wr_en_i && addr_i == ADDR_W'(4)) |=> count == $past(count) + DATA_W'(1));

  // R9
  count_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && addr_i == ADDR_W'(4) |=> count == $past(wdata_i));

  // R3
  ch3_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && count == match[CH_N-1] |=> wdog_match_o);

  // R4
  status_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && addr_i == ADDR_W'(5) && !tick_i |=> (status & $past(wdata_i[CH_N-1:0])) == '0);

  // R6
  ien_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && addr_i == ADDR_W'(7) |=> ien_q == $past(wdata_i[CH_N-1:0]));

  // R7
  wdog_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdog_en_o |=> wdog_en_o);

  // R10
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
endmodule

bind match_timer mt_checker #(.DATA_W(DATA_W), .CH_N(CH_N), .ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tick_i       (tick_i),
  .wr_en_i      (wr_en_i),
  .rd_en_i      (rd_en_i),
  .addr_i       (addr_i),
  .wdata_i      (wdata_i),
  .rdata_o      (rdata_o),
  .wdog_en_o    (wdog_en_o),
  .wdog_match_o (wdog_match_o),
  .count        (count),
  .match        (match),
  .status       (status),
  .ien_q        (ien_q)
);

// File: tb/match_timer_test.sv
module match_timer_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0, wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [3:0]  irq_o;
  logic        wdog_en_o, wdog_match_o;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #2 clk_i = ~clk_i;

  match_timer uut (
    .clk_i, .rst_ni, .tick_i, .wr_en_i, .rd_en_i, .addr_i, .wdata_i,
    .rdata_o, .irq_o, .wdog_en_o, .wdog_match_o
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // one bus cycle: drive after a falling edge, return after the next falling edge
  task automatic op(input logic wr, input logic rd, input logic tk,
                    input logic [2:0] a, input logic [31:0] d);
    wr_en_i = wr; rd_en_i = rd; tick_i = tk; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0; rd_en_i = 1'b0; tick_i = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d); op(1, 0, 0, a, d); endtask
  task automatic tk(); op(0, 0, 1, 3'd0, 32'd0); endtask
  task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
    op(0, 1, 0, a, 32'd0);
    chk(req, rdata_o, exp);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 8; i++) rd_chk("R1", 3'(i), 32'd0);
    chk("R1 irq", {28'd0, irq_o}, 32'd0);
    chk("R1 wdog", {31'd0, wdog_en_o}, 32'd0);
  endtask

  task automatic t_count();
    wr(3'd4, 32'd100);
    rd_chk("R9 preload", 3'd4, 32'd100);
    tk(); tk(); tk();
    rd_chk("R2 three ticks", 3'd4, 32'd103);
    op(0, 0, 0, 3'd0, 32'd0);
    rd_chk("R2 hold", 3'd4, 32'd103);
  endtask

  task automatic t_match();
    wr(3'd0, 32'd200); wr(3'd1, 32'd200); wr(3'd2, 32'd300); wr(3'd3, 32'd5);
    wr(3'd4, 32'd199);
    tk();
    rd_chk("R3 no early hit", 3'd5, 32'd0);
    tk();
    rd_chk("R3 dual hit", 3'd5, 32'h3);
    rd_chk("R3 count", 3'd4, 32'd201);
    chk("R8 gated off", {28'd0, irq_o}, 32'd0);
  endtask

  task automatic t_w1c();
    wr(3'd5, 32'h1);
    rd_chk("R4 clear bit0", 3'd5, 32'h2);
    wr(3'd5, 32'h0);
    rd_chk("R4 zero write", 3'd5, 32'h2);
    wr(3'd5, 32'hF);
    rd_chk("R4 clear all", 3'd5, 32'h0);
  endtask

  task automatic t_setwins();
    wr(3'd4, 32'd300);
    op(1, 0, 1, 3'd5, 32'h4);
    rd_chk("R5 set wins", 3'd5, 32'h4);
    rd_chk("R5 count", 3'd4, 32'd301);
    wr(3'd5, 32'hF);
  endtask

  task automatic t_ien();
    wr(3'd7, 32'hFFFF_FFF5);
    rd_chk("R6 low bits", 3'd7, 32'h5);
    wr(3'd4, 32'd200);
    tk();
    chk("R8 irq 5&3", {28'd0, irq_o}, 32'h1);
    chk("R11 no ch3", {31'd0, wdog_match_o}, 32'd0);
    wr(3'd7, 32'h2);
    chk("R8 irq 2&3", {28'd0, irq_o}, 32'h2);
    wr(3'd7, 32'h0);
    chk("R8 irq off", {28'd0, irq_o}, 32'h0);
    wr(3'd5, 32'hF);
  endtask

  task automatic t_wdog();
    wr(3'd6, 32'hFFFF_FFFE);
    rd_chk("R7 bit0 only", 3'd6, 32'h0);
    wr(3'd6, 32'h1);
    rd_chk("R7 set", 3'd6, 32'h1);
    wr(3'd6, 32'h0);
    rd_chk("R7 sticky", 3'd6, 32'h1);
    chk("R7 pin", {31'd0, wdog_en_o}, 32'd1);
  endtask

  task automatic t_wrap();
    wr(3'd3, 32'hFFFF_FFFF);
    wr(3'd4, 32'hFFFF_FFFF);
    tk();
    rd_chk("R9 wrap", 3'd4, 32'd0);
    rd_chk("R3 ch3 at max", 3'd5, 32'h8);
    chk("R11 ch3 pin", {31'd0, wdog_match_o}, 32'd1);
    wr(3'd7, 32'h8);
    chk("R8 irq ch3", {28'd0, irq_o}, 32'h8);
    wr(3'd5, 32'h8);
    chk("R11 cleared", {31'd0, wdog_match_o}, 32'd0);
  endtask

  task automatic t_load_tick();
    op(1, 0, 1, 3'd4, 32'd5);
    rd_chk("R9 load beats tick", 3'd4, 32'd5);
    tk();
    rd_chk("R2 after load", 3'd4, 32'd6);
    op(0, 0, 1, 3'd0, 32'd0);
    op(0, 0, 0, 3'd0, 32'd0);
    chk("R10 rdata holds", rdata_o, 32'd6);
    rd_chk("R10 unused zero", 3'd5, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_count();
    t_match();
    t_w1c();
    t_setwins();
    t_ien();
    t_wdog();
    t_wrap();
    t_load_tick();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        checks++; errors++;
        $display("FAIL watchdog got=hung exp=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule